// File: doc/BRIEF.md
# Display RAM Write-Pointer Stepper

This block keeps the write pointer of a byte-organised display memory that is 102 columns wide and 9 banks tall. The pointer holds a column value and a bank value. Each byte that arrives as display data is given a linear memory address, built from the pointer. That address goes out with a one-cycle write enable, and the pointer then steps to the next location. A mode bit picks the stepping order. In horizontal order the pointer runs along a bank before it moves to the next bank. In vertical order it runs down a column before it moves to the next column.

A command decoder upstream can load a new column or a new bank at any time. It drives one strobe for each, together with the value. A load is not allowed while the pointer sits on the very last location (column 101, bank 8). It takes effect there only after a no-operation strobe has been seen since the pointer arrived on that location. The memory array itself is outside this block.

Top module: `dptr_top`

## Requirements
- R1: After reset, col_o = 0, bank_o = 0, wr_en_o = 0 and addr_o = 0. A data strobe present while reset is asserted produces no write enable.
- R2: A data strobe (data_stb_i = 1) in a cycle makes wr_en_o = 1 for exactly the following cycle. In that cycle addr_o = bank*102 + col, taken from the pointer held before the step. addr_o keeps the last written address while no write occurs.
- R3: With step_mode_i = 0 (horizontal), a data strobe increments col. From col 101 it returns col to 0 and increments bank.
- R4: With step_mode_i = 1 (vertical), a data strobe increments bank. From bank 8 it returns bank to 0 and increments col.
- R5: A data strobe at col 101, bank 8 moves the pointer to col 0, bank 0 in either mode.
- R6: set_col_stb_i loads col from set_col_i and set_bank_stb_i loads bank from set_bank_i, visible the next cycle. Values above 101 or above 8 load 101 or 8. Both strobes may act in the same cycle.
- R7: While the pointer is at col 101, bank 8, a load strobe has no effect unless nop_stb_i has been pulsed since the pointer last changed. After such a NOP the load takes effect.
- R8: A data strobe in the same cycle as a load strobe wins: the write and the step happen and the load is dropped.
- R9: A cycle with no strobe leaves col_o, bank_o and addr_o unchanged and wr_en_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| data_stb_i | input | 1 | One data byte is to be stored |
| nop_stb_i | input | 1 | No-operation command seen |
| set_col_stb_i | input | 1 | Load column command |
| set_col_i | input | 7 | Column value to load |
| set_bank_stb_i | input | 1 | Load bank command |
| set_bank_i | input | 4 | Bank value to load |
| step_mode_i | input | 1 | 0 = horizontal stepping, 1 = vertical stepping |
| col_o | output | 7 | Current column of the pointer |
| bank_o | output | 4 | Current bank of the pointer |
| addr_o | output | 10 | Linear address of the last written byte |
| wr_en_o | output | 1 | Write enable for the memory, one cycle per byte |

## Verification
Every result shows one clock edge after its strobe. The write enable, the address and the stepped pointer all appear in the cycle after a data strobe. Loads, NOP arming and the ignored loads at the last location are likewise visible one edge later. The bench drives each strobe for one cycle starting at a falling edge and reads the outputs at the next falling edge, so each check looks at exactly the registered result of one stimulus. Full sweeps of all 918 locations in both modes compare every address and pointer value against values computed arithmetically.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    typedef enum logic {
        STEP_HORZ = 1'b0,
        STEP_VERT = 1'b1
    } step_mode_e;
endpackage

// File: rtl/dptr_step.sv
// Next pointer location for one stored byte, in either stepping order.
module dptr_step #(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    localparam int CW = $clog2(COLS),
    localparam int BW = $clog2(BANKS)
) (
    input  logic [CW-1:0]      col,
    input  logic [BW-1:0]      bank,
    input  dptr_pkg::step_mode_e mode,
    output logic [CW-1:0]      col_nx,
    output logic [BW-1:0]      bank_nx
);
    logic col_end, bank_end;

    assign col_end  = (col  == CW'(COLS - 1));
    assign bank_end = (bank == BW'(BANKS - 1));

    always_comb begin
        col_nx  = col;
        bank_nx = bank;
        if (mode == dptr_pkg::STEP_HORZ) begin
            if (col_end) begin
                col_nx  = '0;
                bank_nx = bank_end ? '0 : bank + 1'b1;
            end else begin
                col_nx = col + 1'b1;
            end
        end else begin
            if (bank_end) begin
                bank_nx = '0;
                col_nx  = col_end ? '0 : col + 1'b1;
            end else begin
                bank_nx = bank + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dptr_lin.sv
// Linear byte address: bank-major, COLS bytes per bank.
module dptr_lin #(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    localparam int CW = $clog2(COLS),
    localparam int BW = $clog2(BANKS),
    localparam int AW = $clog2(COLS * BANKS)
) (
    input  logic [CW-1:0] col,
    input  logic [BW-1:0] bank,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ROW_LEN = AW'(COLS);

    assign addr = AW'(bank) * ROW_LEN + AW'(col);
endmodule

// File: rtl/dptr_guard.sv
// Decides whether an address load may act this cycle.
module dptr_guard #(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    localparam int CW = $clog2(COLS),
    localparam int BW = $clog2(BANKS)
) (
    input  logic [CW-1:0] col,
    input  logic [BW-1:0] bank,
    input  logic          armed,
    input  logic          data_stb,
    output logic          at_last,
    output logic          load_ok
);
    assign at_last = (col == CW'(COLS - 1)) && (bank == BW'(BANKS - 1));
    assign load_ok = !data_stb && (!at_last || armed);
endmodule

// File: rtl/dptr_top.sv
module dptr_top #(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    localparam int CW = $clog2(COLS),
    localparam int BW = $clog2(BANKS),
    localparam int AW = $clog2(COLS * BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_stb_i,
    input  logic          nop_stb_i,
    input  logic          set_col_stb_i,
    input  logic [CW-1:0] set_col_i,
    input  logic          set_bank_stb_i,
    input  logic [BW-1:0] set_bank_i,
    input  logic          step_mode_i,
    output logic [CW-1:0] col_o,
    output logic [BW-1:0] bank_o,
    output logic [AW-1:0] addr_o,
    output logic          wr_en_o
);
    typedef struct packed {
        logic [CW-1:0] col;
        logic [BW-1:0] bank;
        logic [AW-1:0] addr;
        logic          wen;
        logic          armed;
    } ptr_state_t;

    ptr_state_t s_d, s_q;

    logic [CW-1:0] step_col;
    logic [BW-1:0] step_bank;
    logic [AW-1:0] lin_addr;
    logic          at_last, load_ok;
    logic [CW-1:0] col_lim;
    logic [BW-1:0] bank_lim;
    logic          armed_w;

    dptr_step #(.COLS(COLS), .BANKS(BANKS)) u_step (
        .col     (s_q.col),
        .bank    (s_q.bank),
        .mode    (dptr_pkg::step_mode_e'(step_mode_i)),
        .col_nx  (step_col),
        .bank_nx (step_bank)
    );

    dptr_lin #(.COLS(COLS), .BANKS(BANKS)) u_lin (
        .col  (s_q.col),
        .bank (s_q.bank),
        .addr (lin_addr)
    );

    dptr_guard #(.COLS(COLS), .BANKS(BANKS)) u_guard (
        .col      (s_q.col),
        .bank     (s_q.bank),
        .armed    (s_q.armed),
        .data_stb (data_stb_i),
        .at_last  (at_last),
        .load_ok  (load_ok)
    );

    // Out-of-range load values saturate at the last column / bank.
    assign col_lim  = (set_col_i  > CW'(COLS - 1))  ? CW'(COLS - 1)  : set_col_i;
    assign bank_lim = (set_bank_i > BW'(BANKS - 1)) ? BW'(BANKS - 1) : set_bank_i;

    always_comb begin
        s_d     = s_q;
        s_d.wen = 1'b0;
        if (data_stb_i) begin
            s_d.addr  = lin_addr;
            s_d.wen   = 1'b1;
            s_d.col   = step_col;
            s_d.bank  = step_bank;
            s_d.armed = 1'b0;
        end else begin
            if (load_ok && (set_col_stb_i || set_bank_stb_i)) begin
                if (set_col_stb_i)  s_d.col  = col_lim;
                if (set_bank_stb_i) s_d.bank = bank_lim;
                s_d.armed = 1'b0;
            end
            if (nop_stb_i) s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign col_o   = s_q.col;
    assign bank_o  = s_q.bank;
    assign addr_o  = s_q.addr;
    assign wr_en_o = s_q.wen;
    assign armed_w = s_q.armed;
endmodule

// File: rtl/dptr_chk.sv
module dptr_chk #(
    parameter int COLS  = 102,
    parameter int BANKS = 9,
    localparam int CW = $clog2(COLS),
    localparam int BW = $clog2(BANKS),
    localparam int AW = $clog2(COLS * BANKS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_stb_i,
    input logic          nop_stb_i,
    input logic          set_col_stb_i,
    input logic          set_bank_stb_i,
    input logic [CW-1:0] col_o,
    input logic [BW-1:0] bank_o,
    input logic [AW-1:0] addr_o,
    input logic          wr_en_o,
    input logic          armed
);
    logic on_last;
    assign on_last = (col_o == CW'(COLS - 1)) && (bank_o == BW'(BANKS - 1));

    // R6 pointer never leaves the legal range
    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (col_o <= CW'(COLS - 1)) && (bank_o <= BW'(BANKS - 1)));

    // R2 write enable follows each data strobe
    a_r2_wen_follows: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb_i |=> wr_en_o);

    // R2 address reported is that of the pointer before the step
    a_r2_addr_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb_i |=> (addr_o == AW'($past(bank_o)) * AW'(COLS) + AW'($past(col_o))));

    // R7 load at last location without NOP leaves pointer in place
    a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (on_last && !armed && !data_stb_i && (set_col_stb_i || set_bank_stb_i))
            |=> ($stable(col_o) && $stable(bank_o)));

    // R9 idle cycle changes nothing
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_stb_i && !nop_stb_i && !set_col_stb_i && !set_bank_stb_i)
            |=> ($stable(col_o) && $stable(bank_o) && $stable(addr_o) && !wr_en_o));
endmodule

bind dptr_top dptr_chk #(.COLS(COLS), .BANKS(BANKS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .data_stb_i     (data_stb_i),
    .nop_stb_i      (nop_stb_i),
    .set_col_stb_i  (set_col_stb_i),
    .set_bank_stb_i (set_bank_stb_i),
    .col_o          (col_o),
    .bank_o         (bank_o),
    .addr_o         (addr_o),
    .wr_en_o        (wr_en_o),
    .armed          (armed_w)
);

// File: tb/sim_dptr_top.sv
module sim_dptr_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 102;
    localparam int NB = 9;
    localparam int NL = NC * NB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_stb = 1'b0, nop_stb = 1'b0, scol_stb = 1'b0, sbank_stb = 1'b0;
    logic [6:0] scol = '0;
    logic [3:0] sbank = '0;
    logic       vmode = 1'b0;
    logic [6:0] col;
    logic [3:0] bank;
    logic [9:0] addr;
    logic       wen;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dptr_top u0 (
        .clk(clk), .rst_n(rst_n),
        .data_stb_i(data_stb), .nop_stb_i(nop_stb),
        .set_col_stb_i(scol_stb), .set_col_i(scol),
        .set_bank_stb_i(sbank_stb), .set_bank_i(sbank),
        .step_mode_i(vmode),
        .col_o(col), .bank_o(bank), .addr_o(addr), .wr_en_o(wen)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; applies strobes for one cycle.
    task automatic cyc(input bit w, input bit n, input bit sc, input int cv,
                       input bit sb, input int bv);
        data_stb = w; nop_stb = n;
        scol_stb = sc; scol = 7'(cv);
        sbank_stb = sb; sbank = 4'(bv);
        @(negedge clk);
        data_stb = 0; nop_stb = 0; scol_stb = 0; sbank_stb = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 200000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 200000", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        data_stb = 1;                 // R1: strobe during reset
        @(negedge clk);
        data_stb = 0;
        check("R1 wen in reset", int'(wen), 0);
        @(negedge clk);
        rst_n = 1;
        check("R1 col", int'(col), 0);
        check("R1 bank", int'(bank), 0);
        check("R1 addr", int'(addr), 0);
        check("R1 wen", int'(wen), 0);

        // R3 / R2 / R5: horizontal sweep of every location
        vmode = 0;
        for (int i = 0; i < NL; i++) begin
            cyc(1, 0, 0, 0, 0, 0);
            check("R2 addr horz", int'(addr), i);
            check("R2 wen horz", int'(wen), 1);
            check("R3 col", int'(col), (i + 1) % NL % NC);
            check("R3 bank", int'(bank), (i + 1) % NL / NC);
        end
        check("R5 horz wrap col", int'(col), 0);

        // R9 idle
        cyc(0, 0, 0, 0, 0, 0);
        check("R9 wen idle", int'(wen), 0);
        check("R9 addr held", int'(addr), NL - 1);

        // R4 / R2 / R5: vertical sweep
        vmode = 1;
        for (int i = 0; i < NL; i++) begin
            cyc(1, 0, 0, 0, 0, 0);
            check("R2 addr vert", int'(addr), (i % NB) * NC + i / NB);
            check("R4 bank", int'(bank), (i + 1) % NL % NB);
            check("R4 col", int'(col), (i + 1) % NL / NB);
        end
        check("R5 vert wrap bank", int'(bank), 0);

        // R6 clamped loads
        for (int x = 0; x < 128; x++) begin
            cyc(0, 0, 1, x, 0, 0);
            check("R6 col load", int'(col), (x > NC - 1) ? NC - 1 : x);
        end
        cyc(0, 0, 1, 0, 0, 0);
        for (int y = 0; y < 16; y++) begin
            cyc(0, 0, 0, 0, 1, y);
            check("R6 bank load", int'(bank), (y > NB - 1) ? NB - 1 : y);
        end
        cyc(0, 0, 1, 50, 1, 3);
        check("R6 both col", int'(col), 50);
        check("R6 both bank", int'(bank), 3);

        // R8 write beats load
        vmode = 0;
        cyc(1, 0, 1, 10, 1, 0);
        check("R8 wen", int'(wen), 1);
        check("R8 addr", int'(addr), 3 * NC + 50);
        check("R8 col", int'(col), 51);
        check("R8 bank", int'(bank), 3);

        // R7 hazard, pointer reached by loads
        cyc(0, 0, 1, 101, 0, 0);
        cyc(0, 0, 0, 0, 1, 8);
        cyc(0, 0, 1, 5, 0, 0);
        check("R7 locked col", int'(col), 101);
        cyc(0, 0, 0, 0, 1, 2);
        check("R7 locked bank", int'(bank), 8);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 5, 0, 0);
        check("R7 unlocked col", int'(col), 5);

        // R7 hazard, pointer reached by a write
        cyc(0, 0, 1, 100, 1, 8);
        cyc(1, 0, 0, 0, 0, 0);
        check("R7 arrival addr", int'(addr), 916);
        cyc(0, 0, 0, 0, 1, 2);
        check("R7 locked after write", int'(bank), 8);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 2);
        check("R7 NOP then load", int'(bank), 2);

        // R5 vertical wrap from last location
        vmode = 1;
        cyc(0, 0, 0, 0, 1, 8);
        cyc(1, 0, 0, 0, 0, 0);
        check("R5 addr last", int'(addr), NL - 1);
        check("R5 col", int'(col), 0);
        check("R5 bank", int'(bank), 0);

        finish_run();
    end
endmodule